// File: doc/BRIEF.md
# Dual-Channel Ping-Pong DMA Ring

This block moves B-channel samples between a byte-per-channel line interface and two circular regions of word memory. The transmit region is read and the receive region is written. Each 32-bit ring word holds one byte for each of the two channels. Software places each region with a start, a half-point and an end word address. It runs both directions with one enable bit. It is told through a masked, write-one-to-clear status register when either direction has passed its half-point or its end, so it can refill or drain the half of the ring that the block has just left.

Every strobe on `line_tick` is one transfer slot. In that slot the block issues one memory read at the transmit pointer and one memory write at the receive pointer, and then advances both pointers. A pointer that has just used its end word jumps back to its start word. The word that comes back from memory is split into per-channel bytes on the transmit line. While the rings are stopped, the line idles at all-ones. The memory port is a plain synchronous word port, and the returned data is valid one cycle after the read enable.

Top module: `pingpong_dma_ring`

## Requirements
- R1: After reset, both memory enables and `irq` are low and `tx_lanes` is all-ones. Start registers read 0, half-point registers read DEPTH/2-1, end registers read DEPTH-1, both current addresses read 0, and the enable reads 0.
- R2: While the enable (bit 0 at offset 0x01) is 0, ticks issue no memory access, `tx_lanes` stays all-ones and each current address equals its start register.
- R3: With the enable set, a tick in cycle c gives `rd_en` and `wr_en` high in cycle c+1. `rd_addr` is the transmit current address (offset 0x14) and `wr_addr` is the receive current address (offset 0x24) as they stood at the tick. Both then advance by one.
- R4: A pointer that transfers at its end address (0x10 transmit, 0x20 receive) moves next to its start address (0x08 transmit, 0x18 receive).
- R5: The receive word written is channel 0 in bits 7:0 and channel 1 in bits 15:8, taken from `rx_lanes` of the same layout, with bits 31:16 zero.
- R6: Bits 7:0 of a returned read word appear on `tx_lanes[7:0]` and bits 15:8 on `tx_lanes[15:8]`, two cycles after `rd_en`.
- R7: The status register (offset 0x06) sets bit 0 when transmit transfers at its half-point address (0x0C) and bit 1 at its end address. It sets bit 2 when receive transfers at its half-point (0x1C) and bit 3 at its end.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. If an event sets a bit in the same cycle as a clear, the bit stays set.
- R9: `irq` is high in the cycle after any status bit 3:0 is set whose mask bit (offset 0x04, bits 3:0) is also set, and low otherwise.
- R10: An event on a status bit that is already set and not being cleared sets overrun bit k+4 of the status register. It stays set until a 1 is written to that bit.
- R11: Reading the current addresses mid-run returns the pointers without altering the sequence of transfers. Register reads return data in the cycle after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| irq | output | 1 | Masked event request |
| line_tick | input | 1 | One transfer slot |
| rx_lanes | input | NCH*8 | Received bytes, channel 0 in low byte |
| tx_lanes | output | NCH*8 | Transmitted bytes, channel 0 in low byte |
| rd_en | output | 1 | Transmit-ring memory read |
| rd_addr | output | AW | Read word address |
| rd_data | input | DW | Read word, valid the cycle after rd_en |
| wr_en | output | 1 | Receive-ring memory write |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Packed receive word |

## Verification
The bench builds the block with AW=10 and DEPTH=16, so the reset-default half-point and end are 7 and 15 and the default transmit ring wraps within sixteen slots. The ten-bit address space also lets the bench keep a full arithmetic model of the memory. It then reprograms short rings of seven and three words, including one whose half-point equals its start. Every slot of a long sweep is compared against a pointer, status and overrun model. Within a few dozen slots this covers repeated wraps, coinciding events, overruns, and clears that land in the same cycle as an event.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  // register byte offsets (software decodes these)
  localparam logic [7:0] OFF_RUN      = 8'h01;
  localparam logic [7:0] OFF_MASK     = 8'h04;
  localparam logic [7:0] OFF_STAT     = 8'h06;
  localparam logic [7:0] OFF_TX_START = 8'h08;
  localparam logic [7:0] OFF_TX_HALF  = 8'h0C;
  localparam logic [7:0] OFF_TX_END   = 8'h10;
  localparam logic [7:0] OFF_TX_CUR   = 8'h14;
  localparam logic [7:0] OFF_RX_START = 8'h18;
  localparam logic [7:0] OFF_RX_HALF  = 8'h1C;
  localparam logic [7:0] OFF_RX_END   = 8'h20;
  localparam logic [7:0] OFF_RX_CUR   = 8'h24;

  localparam int LANE_W = 8;
  localparam int NUM_EV = 4;

  // event vector, bit order fixed by the status register layout
  typedef struct packed {
    logic rx_end;
    logic rx_half;
    logic tx_end;
    logic tx_half;
  } ring_ev_t;
endpackage

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] half_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] ptr,
  output logic          hit_half,
  output logic          hit_end
);
  logic at_last;
  assign at_last  = (ptr == last_addr);
  assign hit_half = run && step && (ptr == half_addr);
  assign hit_end  = run && step && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (!run) begin
      ptr <= start_addr;
    end else if (step) begin
      ptr <= at_last ? start_addr : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ring_event_ctrl.sv
module ring_event_ctrl #(
  parameter int NEV = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev_set,
  input  logic [NEV-1:0] clr_stat,
  input  logic [NEV-1:0] clr_ovr,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] overrun,
  output logic           irq
);
  genvar i;
  generate
    for (i = 0; i < NEV; i++) begin : g_ev
      logic st_b;
      logic ov_b;
      always_ff @(posedge clk) begin
        if (rst) begin
          st_b <= 1'b0;
          ov_b <= 1'b0;
        end else begin
          st_b <= ev_set[i] | (st_b & ~clr_stat[i]);
          ov_b <= (ev_set[i] & st_b & ~clr_stat[i]) | (ov_b & ~clr_ovr[i]);
        end
      end
      assign status[i]  = st_b;
      assign overrun[i] = ov_b;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end
endmodule

// File: rtl/pingpong_dma_ring.sv
module pingpong_dma_ring
  import pdr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NCH   = 2,
  parameter int DEPTH = 512,
  localparam int LW   = NCH * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          line_tick,
  input  logic [LW-1:0] rx_lanes,
  output logic [LW-1:0] tx_lanes,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [AW-1:0] HALF_RST = AW'(DEPTH / 2 - 1);
  localparam logic [AW-1:0] END_RST  = AW'(DEPTH - 1);

  logic          run_q;
  logic [3:0]    mask_q;
  logic [AW-1:0] tx_start, tx_half, tx_end;
  logic [AW-1:0] rx_start, rx_half, rx_end;
  logic [AW-1:0] tx_ptr, rx_ptr;
  logic          tx_hh, tx_he, rx_hh, rx_he;
  logic          step;
  logic          rd_pend;
  ring_ev_t      ev;
  logic [3:0]    status, overrun;
  logic          stat_we;
  logic [3:0]    clr_stat, clr_ovr;

  function automatic logic sel(input logic [7:0] off);
    return reg_we && (reg_addr == off);
  endfunction

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      mask_q   <= '0;
      tx_start <= '0;
      tx_half  <= HALF_RST;
      tx_end   <= END_RST;
      rx_start <= '0;
      rx_half  <= HALF_RST;
      rx_end   <= END_RST;
    end else begin
      if (sel(OFF_RUN))      run_q    <= reg_wdata[0];
      if (sel(OFF_MASK))     mask_q   <= reg_wdata[3:0];
      if (sel(OFF_TX_START)) tx_start <= reg_wdata[AW-1:0];
      if (sel(OFF_TX_HALF))  tx_half  <= reg_wdata[AW-1:0];
      if (sel(OFF_TX_END))   tx_end   <= reg_wdata[AW-1:0];
      if (sel(OFF_RX_START)) rx_start <= reg_wdata[AW-1:0];
      if (sel(OFF_RX_HALF))  rx_half  <= reg_wdata[AW-1:0];
      if (sel(OFF_RX_END))   rx_end   <= reg_wdata[AW-1:0];
    end
  end

  assign step = line_tick && run_q;

  ring_addr_gen #(.AW(AW)) u_tx_ring (
    .clk(clk), .rst(rst), .run(run_q), .step(step),
    .start_addr(tx_start), .half_addr(tx_half), .last_addr(tx_end),
    .ptr(tx_ptr), .hit_half(tx_hh), .hit_end(tx_he)
  );

  ring_addr_gen #(.AW(AW)) u_rx_ring (
    .clk(clk), .rst(rst), .run(run_q), .step(step),
    .start_addr(rx_start), .half_addr(rx_half), .last_addr(rx_end),
    .ptr(rx_ptr), .hit_half(rx_hh), .hit_end(rx_he)
  );

  assign ev.tx_half = tx_hh;
  assign ev.tx_end  = tx_he;
  assign ev.rx_half = rx_hh;
  assign ev.rx_end  = rx_he;

  assign stat_we  = sel(OFF_STAT);
  assign clr_stat = stat_we ? reg_wdata[3:0] : 4'h0;
  assign clr_ovr  = stat_we ? reg_wdata[7:4] : 4'h0;

  ring_event_ctrl #(.NEV(NUM_EV)) u_events (
    .clk(clk), .rst(rst), .ev_set(ev), .clr_stat(clr_stat),
    .clr_ovr(clr_ovr), .mask(mask_q), .status(status),
    .overrun(overrun), .irq(irq)
  );

  // memory side: one read and one write per slot
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      rd_addr <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_en   <= step;
      wr_en   <= step;
      rd_pend <= rd_en;
      if (step) begin
        rd_addr <= tx_ptr;
        wr_addr <= rx_ptr;
        wr_data <= {{(DW-LW){1'b0}}, rx_lanes};
      end
    end
  end

  // line side: mark idle while stopped
  always_ff @(posedge clk) begin
    if (rst || !run_q)  tx_lanes <= '1;
    else if (rd_pend)   tx_lanes <= rd_data[LW-1:0];
  end

  // register readback, one cycle latency, no side effects
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFF_RUN:      reg_rdata <= {31'h0, run_q};
        OFF_MASK:     reg_rdata <= {28'h0, mask_q};
        OFF_STAT:     reg_rdata <= {24'h0, overrun, status};
        OFF_TX_START: reg_rdata <= 32'(tx_start);
        OFF_TX_HALF:  reg_rdata <= 32'(tx_half);
        OFF_TX_END:   reg_rdata <= 32'(tx_end);
        OFF_TX_CUR:   reg_rdata <= 32'(tx_ptr);
        OFF_RX_START: reg_rdata <= 32'(rx_start);
        OFF_RX_HALF:  reg_rdata <= 32'(rx_half);
        OFF_RX_END:   reg_rdata <= 32'(rx_end);
        OFF_RX_CUR:   reg_rdata <= 32'(rx_ptr);
        default:      reg_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, rd_data};
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run_q,
  input logic          line_tick,
  input logic [AW-1:0] tx_ptr,
  input logic [AW-1:0] tx_start,
  input logic [AW-1:0] tx_end,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [LW-1:0] rx_lanes,
  input logic [LW-1:0] tx_lanes,
  input logic          irq,
  input logic [3:0]    status,
  input logic [3:0]    mask_q,
  input logic [3:0]    overrun,
  input logic          reg_we,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata
);
  logic [3:0] ovr_clr;
  assign ovr_clr = (reg_we && reg_addr == 8'h06) ? reg_wdata[7:4] : 4'h0;

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (!rd_en && !wr_en && tx_lanes == {LW{1'b1}}));

  p_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (line_tick && run_q) |=> (rd_en && wr_en && rd_addr == $past(tx_ptr)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (line_tick && run_q && tx_ptr == tx_end) |=> (tx_ptr == $past(tx_start)));

  p_pack_r5: assert property (@(posedge clk) disable iff (rst)
    (line_tick && run_q) |=> (wr_data == {{(DW-LW){1'b0}}, $past(rx_lanes)}));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & mask_q))));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((overrun & $past(overrun & ~ovr_clr)) == $past(overrun & ~ovr_clr)));
endmodule

bind pingpong_dma_ring pdr_checker #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .line_tick(line_tick),
  .tx_ptr(tx_ptr), .tx_start(tx_start), .tx_end(tx_end),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_data(wr_data),
  .rx_lanes(rx_lanes), .tx_lanes(tx_lanes), .irq(irq),
  .status(status), .mask_q(mask_q), .overrun(overrun),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_pingpong_dma_ring.sv
`timescale 1ns/1ps
module sim_pingpong_dma_ring;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int LW = 16;

  logic clk = 0;
  logic rst = 1;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq;
  logic line_tick = 0;
  logic [LW-1:0] rx_lanes = 0;
  logic [LW-1:0] tx_lanes;
  logic rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = 0;
  logic [DW-1:0] wr_data;

  always #5 clk = ~clk;

  pingpong_dma_ring #(.AW(AW), .DW(DW), .NCH(2), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .line_tick(line_tick), .rx_lanes(rx_lanes), .tx_lanes(tx_lanes),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] word_at(input logic [AW-1:0] a);
    return {16'hC3C3, a[7:0] ^ 8'hA5, a[7:0] + 8'd3};
  endfunction

  logic [31:0] mem [0:(1<<AW)-1];
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [AW-1:0] m_ts = 0, m_th = AW'(DEPTH/2-1), m_te = AW'(DEPTH-1);
  logic [AW-1:0] m_rs = 0, m_rh = AW'(DEPTH/2-1), m_re = AW'(DEPTH-1);
  logic [AW-1:0] m_tp = 0, m_rp = 0;
  logic [3:0] m_st = 0, m_ov = 0, m_mask = 0;
  logic m_run = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    case (a)
      8'h01: begin m_run = d[0]; if (!d[0]) begin m_tp = m_ts; m_rp = m_rs; end end
      8'h04: m_mask = d[3:0];
      8'h06: begin m_st = m_st & ~d[3:0]; m_ov = m_ov & ~d[7:4]; end
      8'h08: begin m_ts = d[AW-1:0]; if (!m_run) m_tp = m_ts; end
      8'h0C: m_th = d[AW-1:0];
      8'h10: m_te = d[AW-1:0];
      8'h18: begin m_rs = d[AW-1:0]; if (!m_run) m_rp = m_rs; end
      8'h1C: m_rh = d[AW-1:0];
      8'h20: m_re = d[AW-1:0];
      default: ;
    endcase
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_tick(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] clrb);
    logic [AW-1:0] a, b;
    logic [3:0] setv;
    a = m_tp; b = m_rp;
    @(negedge clk);
    line_tick = 1; rx_lanes = {r1, r0};
    if (clrb != 0) begin reg_we = 1; reg_addr = 8'h06; reg_wdata = {24'h0, clrb}; end
    setv = 4'h0;
    if (m_run) begin
      setv = {b == m_re, b == m_rh, a == m_te, a == m_th};
      m_tp = (a == m_te) ? m_ts : a + 1'b1;
      m_rp = (b == m_re) ? m_rs : b + 1'b1;
    end
    m_ov = (m_ov & ~clrb[7:4]) | (setv & m_st & ~clrb[3:0]);
    m_st = (m_st & ~clrb[3:0]) | setv;
    @(negedge clk);
    line_tick = 0; reg_we = 0; reg_addr = 8'h06;
    if (m_run) begin
      check("R3 rd_en", 32'(rd_en), 32'd1);
      check("R3 wr_en", 32'(wr_en), 32'd1);
      check("R3/R4 rd_addr", 32'(rd_addr), 32'(a));
      check("R3/R4 wr_addr", 32'(wr_addr), 32'(b));
      check("R5 wr_data", wr_data, {16'h0, r1, r0});
    end else begin
      check("R2 no access", 32'({rd_en, wr_en}), 32'd0);
    end
    @(negedge clk);
    check("R7/R8/R10 status", reg_rdata, {24'h0, m_ov, m_st});
    check("R9 irq", 32'(irq), 32'(|(m_st & m_mask)));
    @(negedge clk);
    if (m_run) check("R6 tx_lanes", 32'(tx_lanes), {16'h0, word_at(a)[15:0]});
    else       check("R2 mark idle", 32'(tx_lanes), 32'h0000FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < (1 << AW); i++) mem[i] = word_at(AW'(i));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_en", 32'(rd_en), 0);
    check("R1 wr_en", 32'(wr_en), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 tx idle", 32'(tx_lanes), 32'h0000FFFF);
    rreg(8'h0C, d); check("R1 tx half", d, DEPTH/2-1);
    rreg(8'h10, d); check("R1 tx end", d, DEPTH-1);
    rreg(8'h1C, d); check("R1 rx half", d, DEPTH/2-1);
    rreg(8'h20, d); check("R1 rx end", d, DEPTH-1);
    rreg(8'h08, d); check("R1 tx start", d, 0);
    rreg(8'h14, d); check("R1 tx cur", d, 0);
    rreg(8'h24, d); check("R1 rx cur", d, 0);
    rreg(8'h01, d); check("R1 run", d, 0);

    // R2 idle before enable
    do_tick(8'h11, 8'h22, 8'h00);

    // default transmit ring, receive ring moved away
    wreg(8'h18, 32'h200); wreg(8'h1C, 32'h207); wreg(8'h20, 32'h20F);
    rreg(8'h24, d); check("R2 cur follows start", d, 32'h200);
    rreg(8'h18, d); check("R11 readback", d, 32'h200);
    wreg(8'h04, 0);
    wreg(8'h01, 1);
    for (int i = 0; i < 20; i++) do_tick(8'(i * 7), ~8'(i), 8'h00);

    // R2 stop
    wreg(8'h01, 0);
    do_tick(8'h5A, 8'hA5, 8'h00);
    rreg(8'h14, d); check("R2 tx cur at start", d, 32'(m_ts));
    rreg(8'h24, d); check("R2 rx cur at start", d, 32'(m_rs));
    wreg(8'h06, 32'hFF);
    rreg(8'h06, d); check("R8 cleared", d, 0);

    // short rings, half equal to start on receive
    wreg(8'h08, 32'h30); wreg(8'h0C, 32'h33); wreg(8'h10, 32'h36);
    wreg(8'h18, 32'h300); wreg(8'h1C, 32'h300); wreg(8'h20, 32'h302);
    wreg(8'h04, 32'h5);
    wreg(8'h01, 1);
    for (int i = 0; i < 30; i++) begin
      do_tick(8'(i + 8'h40), 8'(i ^ 8'h3C), 8'h00);
      if (i == 10) begin
        rreg(8'h14, d); check("R11 tx cur mid-run", d, 32'(m_tp));
        rreg(8'h24, d); check("R11 rx cur mid-run", d, 32'(m_rp));
      end
    end
    // R8 clears in the same cycle as events
    for (int i = 0; i < 10; i++) do_tick(8'(i), 8'(i + 1), 8'h0F);
    do_tick(8'h77, 8'h88, 8'hF0);
    wreg(8'h04, 32'hF);
    for (int i = 0; i < 8; i++) do_tick(8'(i * 3), 8'(i * 5), 8'h00);
    wreg(8'h06, 32'h0F);
    rreg(8'h06, d); check("R10 overrun sticky after status clear", d, {24'h0, m_ov, m_st});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule